// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a successive-approximation converter. Software writes a run bit to 1 to start a conversion. The block then steers an eight-way analog multiplexer to the chosen input, holds a sample phase, and binary-searches a trial code on an external DAC. It reads one comparator bit per trial. At the end it stores the finished code in a result register and pulses a done flag. The comparator, ladder and DAC sit outside the block.

Each conversion has a fixed length in conversion-clock ticks, set by the resolution (8 or 10 bits) and by whether sample-and-hold is on. The conversion clock is the system clock divided by 1, 2 or 4. Any ticks not spent on bit trials are spent sampling before the first trial. One-shot mode converts once and stops. Repeat mode converts the same input back to back until software clears the run bit, and it always works at 8 bits. The block will not start while the reference-connect input is low. Channel, resolution, mode, sample-and-hold and divider are captured when a conversion is started from idle.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A write (`start_wr`=1) with `start_val`=1 while `ref_en`=1 and the block is idle sets `busy` on the following cycle and begins a conversion.
- R2: While `ref_en`=0, a write of 1 to an idle block is ignored. `busy` stays 0, `sample_o` stays 0 and no `done` follows.
- R3: `done` rises exactly L×N clock cycles after the start-write edge. L is 49 (8-bit) or 59 (10-bit) without sample-and-hold, and 28 (8-bit) or 33 (10-bit) with it. N is the divide ratio.
- R4: `div_sel` selects N: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R5: The result is the binary search of the comparator, MSB first, where `cmp_in`=1 means the input is at or above `dac_code`. In 10-bit mode the result is the full code. In 8-bit mode it is right-aligned in `result` with bits 9:8 zero, and `dac_code` is right-aligned in the same way.
- R6: `sample_o` is high for the first (L−B)×N cycles of a conversion, where B is the number of bits, and `dac_code` is 0 whenever `sample_o` is high.
- R7: `done` is a one-cycle pulse. In one-shot mode `busy` is 0 in the cycle `done` is high.
- R8: In repeat mode, conversions run back to back and `done` recurs every L×N cycles. Each conversion samples the input afresh.
- R9: Repeat mode forces 8-bit operation even when `res_sel`=1.
- R10: Writing `start_val`=0 clears `busy` on the next cycle and aborts the conversion. `sample_o` and `dac_code` return to 0, no `done` follows, and `result` keeps its old value.
- R11: `mux_sel` holds the channel captured at start. Changing `chan_sel` during a conversion has no effect on it or on the result.
- R12: After reset, `busy`, `done`, `sample_o`, `dac_code` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | One-cycle write strobe for the run bit |
| start_val | input | 1 | Value written to the run bit |
| ref_en | input | 1 | Reference ladder connected; start is refused when 0 |
| chan_sel | input | 3 | Analog input channel 0 to 7 |
| res_sel | input | 1 | 1 selects 10-bit, 0 selects 8-bit |
| rpt_sel | input | 1 | 1 selects repeat mode |
| sh_sel | input | 1 | 1 enables sample-and-hold timing |
| div_sel | input | 2 | Conversion clock divider select |
| cmp_in | input | 1 | Comparator: input at or above trial code |
| mux_sel | output | 3 | Channel multiplexer select |
| dac_code | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sample switch control |
| busy | output | 1 | Run bit read-back |
| result | output | 10 | Last finished conversion code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- `cmp_in` is a settled function of the current `dac_code` and the selected input by each conversion-clock tick.
- `start_wr` is a strobe that software drives at most once per cycle.

The bench meets both conditions. Its comparator is a continuous function of `dac_code`, `mux_sel` and a per-channel stored voltage. All stimulus changes on the falling edge, and every write is a single-cycle pulse. Configuration inputs and `chan_sel` are randomised freely after a start, because the block must ignore them until the next start from idle.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef struct packed {
    logic       res10;
    logic       rpt;
    logic       sh;
    logic [1:0] div;
  } sar_cfg_t;

  function automatic logic [1:0] div_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    div_limit = 2'd0;
      2'd1:    div_limit = 2'd1;
      default: div_limit = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/sar_prescale.sv
module sar_prescale
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div,
  output logic       tick
);

  logic [1:0] cnt_q, cnt_d;
  logic [1:0] lim;

  always_comb begin
    lim   = div_limit(div);
    tick  = run && (cnt_q == lim);
    cnt_d = cnt_q;
    if (!run)      cnt_d = 2'd0;
    else if (tick) cnt_d = 2'd0;
    else           cnt_d = cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  // R4: with a divide ratio above 1, ticks never fall on adjacent cycles
  a_r4_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && lim != 2'd0) |=> !tick);

endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl #(
  parameter int RES_W     = 10,
  parameter int LO_W      = 8,
  parameter int LEN_LO    = 49,
  parameter int LEN_HI    = 59,
  parameter int LEN_LO_SH = 28,
  parameter int LEN_HI_SH = 33,
  parameter int CNT_W     = 6,
  parameter int POS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             res10,
  input  logic             sh,
  output logic             sampling,
  output logic             trial,
  output logic [POS_W-1:0] pos,
  output logic             last
);

  localparam logic [CNT_W-1:0] L_LO    = CNT_W'(LEN_LO);
  localparam logic [CNT_W-1:0] L_HI    = CNT_W'(LEN_HI);
  localparam logic [CNT_W-1:0] L_LO_SH = CNT_W'(LEN_LO_SH);
  localparam logic [CNT_W-1:0] L_HI_SH = CNT_W'(LEN_HI_SH);
  localparam logic [CNT_W-1:0] B_LO    = CNT_W'(LO_W);
  localparam logic [CNT_W-1:0] B_HI    = CNT_W'(RES_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len, nbits, settle, off, p;

  always_comb begin
    if (res10) len = sh ? L_HI_SH : L_HI;
    else       len = sh ? L_LO_SH : L_LO;
    nbits    = res10 ? B_HI : B_LO;
    settle   = len - nbits;
    sampling = run && (cnt_q < settle);
    trial    = run && !(cnt_q < settle);
    off      = cnt_q - settle;
    p        = nbits - CNT_W'(1) - off;
    pos      = p[POS_W-1:0];
    last     = trial && (cnt_q == len - CNT_W'(1));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the tick counter never runs past the conversion length
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < len));

  // R10: an idle engine holds its counter at zero
  a_r10_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10,
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             trial,
  input  logic [POS_W-1:0] pos,
  input  logic             cmp,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] code_fin
);

  logic [RES_W-1:0] bits_q, bits_d, probe;

  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    always_comb begin
      probe[i] = (pos == POS_W'(i));
      if (clr)                  bits_d[i] = 1'b0;
      else if (upd && probe[i]) bits_d[i] = cmp;
      else                      bits_d[i] = bits_q[i];
    end
  end

  always_comb begin
    dac_code = trial ? (bits_q | probe) : '0;
    code_fin = cmp ? (bits_q | probe) : bits_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  // R5: a trial code always has the bit under test set
  a_r5_probe_set: assert property (@(posedge clk) disable iff (!rst_n)
    trial |-> ((dac_code & probe) != '0));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int LO_W      = 8,
  parameter int CH_W      = 3,
  parameter int LEN_LO    = 49,
  parameter int LEN_HI    = 59,
  parameter int LEN_LO_SH = 28,
  parameter int LEN_HI_SH = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             start_val,
  input  logic             ref_en,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             res_sel,
  input  logic             rpt_sel,
  input  logic             sh_sel,
  input  logic [1:0]       div_sel,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_o,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             done
);

  localparam int LEN_MAX = (LEN_HI > LEN_LO) ? LEN_HI : LEN_LO;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);
  localparam int POS_W   = $clog2(RES_W);

  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic             go_q, go_d;
  sar_cfg_t         cfg_q, cfg_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [RES_W-1:0] result_q, result_d;
  logic             done_q, done_d;
  logic             tick, sampling, trial, last, complete, start_set;
  logic [POS_W-1:0] pos;
  logic [RES_W-1:0] code_fin;

  sar_prescale u_div (
    .clk   (clk),
    .rst_n (rst_ni),
    .run   (go_q),
    .div   (cfg_q.div),
    .tick  (tick)
  );

  sar_step_ctrl #(
    .RES_W(RES_W), .LO_W(LO_W),
    .LEN_LO(LEN_LO), .LEN_HI(LEN_HI), .LEN_LO_SH(LEN_LO_SH), .LEN_HI_SH(LEN_HI_SH),
    .CNT_W(CNT_W), .POS_W(POS_W)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_ni),
    .run      (go_q),
    .tick     (tick),
    .res10    (cfg_q.res10),
    .sh       (cfg_q.sh),
    .sampling (sampling),
    .trial    (trial),
    .pos      (pos),
    .last     (last)
  );

  sar_approx #(.RES_W(RES_W), .POS_W(POS_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clr      (!go_q || complete),
    .upd      (tick && trial),
    .trial    (trial),
    .pos      (pos),
    .cmp      (cmp_in),
    .dac_code (dac_code),
    .code_fin (code_fin)
  );

  always_comb begin
    complete  = tick && last;
    start_set = start_wr && start_val && ref_en && !go_q;
    go_d      = go_q;
    cfg_d     = cfg_q;
    chan_d    = chan_q;
    result_d  = result_q;
    done_d    = complete;
    if (start_wr)                     go_d = start_val && (go_q || ref_en);
    else if (complete && !cfg_q.rpt)  go_d = 1'b0;
    if (start_set) begin
      cfg_d.res10 = res_sel && !rpt_sel;
      cfg_d.rpt   = rpt_sel;
      cfg_d.sh    = sh_sel;
      cfg_d.div   = div_sel;
      chan_d      = chan_sel;
    end
    if (complete) result_d = code_fin;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q     <= 1'b0;
      cfg_q    <= '0;
      chan_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      go_q     <= go_d;
      cfg_q    <= cfg_d;
      chan_q   <= chan_d;
      result_q <= result_d;
      done_q   <= done_d;
    end
  end

  assign mux_sel  = chan_q;
  assign sample_o = sampling;
  assign busy     = go_q;
  assign result   = result_q;
  assign done     = done_q;

  // R2: a start only takes hold with the reference connected
  a_r2_start_needs_ref: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(go_q) |-> $past(ref_en));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R7: one-shot conversions drop the run bit as they finish
  a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_q && !cfg_q.rpt && !$past(start_wr)) |-> !go_q);

  // R9: repeat mode never runs at the high resolution
  a_r9_rpt_lo_res: assert property (@(posedge clk) disable iff (!rst_ni)
    (go_q && cfg_q.rpt) |-> !cfg_q.res10);

  // R5: low-resolution results keep the upper bits clear
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_q && !cfg_q.res10) |-> (result_q[RES_W-1:LO_W] == '0));

  // R6: no trial code is driven while sampling
  a_r6_dac_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    sample_o |-> (dac_code == '0));

endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_wr, start_val, ref_en, res_sel, rpt_sel, sh_sel, cmp_in;
  logic [2:0] chan_sel;
  logic [1:0] div_sel;
  logic [2:0] mux_sel;
  logic [9:0] dac_code, result;
  logic       sample_o, busy, done;

  logic [9:0] vin [8];
  bit         cur_hi;
  int         nvec = 0;
  int         nfail = 0;

  always #2 clk = ~clk;

  sar_conv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_val(start_val),
    .ref_en(ref_en), .chan_sel(chan_sel), .res_sel(res_sel), .rpt_sel(rpt_sel),
    .sh_sel(sh_sel), .div_sel(div_sel), .cmp_in(cmp_in), .mux_sel(mux_sel),
    .dac_code(dac_code), .sample_o(sample_o), .busy(busy), .result(result),
    .done(done)
  );

  // behavioural comparator against the stored per-channel input
  assign cmp_in = cur_hi ? (vin[mux_sel] >= dac_code)
                         : ({2'b00, vin[mux_sel][9:2]} >= dac_code);

  function automatic int exp_len(bit hi, bit sh);
    if (sh) return hi ? 33 : 28;
    return hi ? 59 : 49;
  endfunction

  function automatic int exp_div(logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 2 : 4;
  endfunction

  function automatic int exp_code(bit hi, logic [9:0] v);
    return hi ? int'(v) : int'(v[9:2]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_run(input bit val);
    @(negedge clk);
    start_wr  = 1'b1;
    start_val = val;
    @(negedge clk);
    start_wr  = 1'b0;
  endtask

  // one-shot conversion with full timing and result checks
  task automatic oneshot(input logic [2:0] ch, input logic [9:0] v, input bit hi,
                         input bit sh, input logic [1:0] d);
    int n, ns, len, dv, frac;
    vin[ch]  = v;
    chan_sel = ch;
    res_sel  = hi;
    rpt_sel  = 1'b0;
    sh_sel   = sh;
    div_sel  = d;
    cur_hi   = hi;
    len      = exp_len(hi, sh);
    dv       = exp_div(d);
    frac     = len - (hi ? 10 : 8);
    write_run(1'b1);
    chk("R1 busy after start", int'(busy), 1);
    // R11: selection changes after start are ignored
    chan_sel = 3'($urandom_range(0, 7));
    res_sel  = 1'($urandom_range(0, 1));
    sh_sel   = 1'($urandom_range(0, 1));
    div_sel  = 2'($urandom_range(0, 3));
    n  = 1;
    ns = 0;
    while (!done && n < 2000) begin
      if (sample_o) ns++;
      chk("R11 mux holds channel", int'(mux_sel), int'(ch));
      @(negedge clk);
      n++;
    end
    chk("R3 R4 conversion length", n - 1, len * dv);
    chk("R6 sample cycles", ns, frac * dv);
    chk("R5 result code", int'(result), exp_code(hi, v));
    chk("R7 busy cleared at done", int'(busy), 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int n;
    logic [9:0] keep;
    void'($urandom(32'h5A17_C0DE));
    rst_n = 1'b0; start_wr = 1'b0; start_val = 1'b0; ref_en = 1'b1;
    chan_sel = '0; res_sel = 1'b0; rpt_sel = 1'b0; sh_sel = 1'b0; div_sel = '0;
    cur_hi = 1'b0;
    for (int i = 0; i < 8; i++) vin[i] = 10'($urandom_range(0, 1023));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(done), 0);
    chk("R12 sample", int'(sample_o), 0);
    chk("R12 dac", int'(dac_code), 0);
    chk("R12 result", int'(result), 0);

    // R2 start refused without reference
    ref_en = 1'b0;
    write_run(1'b1);
    chk("R2 busy stays low", int'(busy), 0);
    n = 0;
    for (int k = 0; k < 300; k++) begin
      if (done || sample_o) n++;
      @(negedge clk);
    end
    chk("R2 no activity", n, 0);
    ref_en = 1'b1;

    // directed corners
    oneshot(3'd0, 10'd0,    1'b1, 1'b0, 2'd0);
    oneshot(3'd7, 10'd1023, 1'b1, 1'b1, 2'd1);
    oneshot(3'd3, 10'd3,    1'b0, 1'b0, 2'd2);
    oneshot(3'd5, 10'd1023, 1'b0, 1'b1, 2'd3);
    oneshot(3'd1, 10'd512,  1'b1, 1'b0, 2'd2);

    // random one-shot conversions
    for (int it = 0; it < 30; it++) begin
      for (int i = 0; i < 8; i++) vin[i] = 10'($urandom_range(0, 1023));
      oneshot(3'($urandom_range(0, 7)), 10'($urandom_range(0, 1023)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)));
    end

    // R8 R9 repeat mode with high resolution requested
    vin[2] = 10'd801;
    chan_sel = 3'd2; res_sel = 1'b1; rpt_sel = 1'b1; sh_sel = 1'b0; div_sel = 2'd1;
    cur_hi = 1'b0;
    write_run(1'b1);
    n = 1;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R9 repeat forced to 8-bit length", n - 1, 49 * 2);
    chk("R9 repeat result 8-bit", int'(result), 801 >> 2);
    chk("R8 busy held in repeat", int'(busy), 1);
    vin[2] = 10'd77;
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 2000);
    chk("R8 repeat period", n, 49 * 2);
    chk("R8 repeat resamples", int'(result), 77 >> 2);

    // R10 abort mid-conversion
    repeat (20) @(negedge clk);
    vin[2] = 10'd1000;
    keep = result;
    write_run(1'b0);
    chk("R10 busy cleared", int'(busy), 0);
    chk("R10 sample low", int'(sample_o), 0);
    chk("R10 dac idle", int'(dac_code), 0);
    n = 0;
    for (int k = 0; k < 300; k++) begin
      if (done) n++;
      @(negedge clk);
    end
    chk("R10 no done after abort", n, 0);
    chk("R10 result kept", int'(result), int'(keep));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule